// File: doc/BRIEF.md
# Leading-Two Jet Pair Angular Trigger

On every bunch crossing, each of 32 source modules delivers four jet candidates to this block, together with a presence mask. The block ranks all 128 candidates by energy and keeps the two largest present ones. It passes through a registered pipeline of six levels. The first level reduces each source's four candidates to a sorted pair. The next five levels merge neighbouring sorted pairs, halving the list count each time, until one pair is left.

The leader's position and the runner-up's position are joined into an address. That address reads a one-bit programmable table, which encodes any cut in pseudorapidity and azimuth the user wants, for example a minimum azimuthal separation. Registering the table bit gives one trigger decision per crossing. The table is loaded through a simple write port and is cleared by reset.

The pipeline clock is meant to run at several times the crossing rate, so the seven-cycle latency fits within three crossings. A frame-valid strobe qualifies each input frame.

Top module: `jet_pair_trigger`

## Requirements
- R1: After reset the decision output is 0 and every table bit is 0. Until the table is written, the decision stays 0 for any input.
- R2: A frame presented while frameValid is 0 yields decision 0 in its output slot, whatever its candidate and presence bits hold.
- R3: Candidate k (0..3) of source s sits at srcCands[(s*4+k)*14 +: 14], with energy in bits 13:6, η index in bits 5:3 and φ index in bits 2:0. It is present when srcPresence[s*8+k] is 1. Presence bits 7:4 of each source have no effect on the decision.
- R4: Candidates are ranked by energy, where an absent candidate counts as energy 0. At equal energy a present candidate outranks an absent one. Any remaining tie goes to the lower source index, then to the lower candidate index.
- R5: If fewer than two candidates of a frame are present, the decision for that frame is 0.
- R6: With two present candidates, the decision is the table bit at address {η1, φ1, η2, φ2}. Here 1 is the leader and 2 is the runner-up, with η1 in address bits 11:9 and φ2 in bits 2:0.
- R7: On a rising edge with lutWrEn at 1, the table bit at lutWrAddr takes lutWrData. A lookup made at that same edge still sees the old bit.
- R8: The decision for a frame sampled at rising edge e appears after rising edge e+7. A new frame may be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| frameValid | input | 1 | Qualifies the frame on srcCands/srcPresence |
| srcCands | input | 1792 | 128 candidates of 14 bits, source-major |
| srcPresence | input | 256 | 8 presence bits per source; low 4 used |
| lutWrEn | input | 1 | Table write enable |
| lutWrAddr | input | 12 | Table write address |
| lutWrData | input | 1 | Table write data |
| decision | output | 1 | Trigger decision bit per frame |

## Verification
The assertions take for granted three things about the inputs. The inputs carry no unknown values at the sampling edge. Reset is held for at least one edge before traffic starts. The table write address is meaningful whenever its enable is high. The stimulus changes every input only on the falling clock edge and drives all vectors from zero-initialised variables. It holds lutWrEn low during reset, so the ordering, pair-presence, gating and write-landing properties see only defined data. Table rewrites interleaved with live frames exercise the same-edge lookup order.

// File: rtl/jet_topo_pkg.sv
package jet_topo_pkg;
  localparam int ENERGY_W = 8;
  localparam int ETA_W = 3;
  localparam int PHI_W = 3;
  localparam int CAND_W = ENERGY_W + ETA_W + PHI_W;
  localparam int PRES_W = 8;
  localparam int CANDS_PER_SRC = 4;
  localparam int LUT_AW = 2 * (ETA_W + PHI_W);
  localparam int LUT_DEPTH = 1 << LUT_AW;

  typedef struct packed {
    logic [ENERGY_W-1:0] energy;
    logic                valid;
    logic [ETA_W-1:0]    eta;
    logic [PHI_W-1:0]    phi;
  } jet_t;

  typedef struct packed {
    jet_t first;
    jet_t second;
  } pair_t;

  typedef struct packed {
    logic captureFrame;
    logic decideFrame;
  } strobes_t;

  // lower-index operand passed as a; it wins ties
  function automatic logic beats(jet_t a, jet_t b);
    return {a.energy, a.valid} >= {b.energy, b.valid};
  endfunction

  function automatic pair_t sortTwo(jet_t lo, jet_t hi);
    pair_t r;
    if (beats(lo, hi)) begin
      r.first = lo;
      r.second = hi;
    end else begin
      r.first = hi;
      r.second = lo;
    end
    return r;
  endfunction

  function automatic pair_t mergePairs(pair_t lo, pair_t hi);
    pair_t r;
    if (beats(lo.first, hi.first)) begin
      r.first = lo.first;
      r.second = beats(lo.second, hi.first) ? lo.second : hi.first;
    end else begin
      r.first = hi.first;
      r.second = beats(lo.first, hi.second) ? lo.first : hi.second;
    end
    return r;
  endfunction
endpackage

// File: rtl/topo_ctrl.sv
module topo_ctrl
  import jet_topo_pkg::*;
#(
  parameter int TREE_DEPTH = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     frameValid,
  output strobes_t strobes
);
  logic [TREE_DEPTH:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[TREE_DEPTH-1:0], frameValid};
  end

  assign strobes.captureFrame = frameValid;
  assign strobes.decideFrame  = validPipe[TREE_DEPTH];
endmodule

// File: rtl/topo_sort_tree.sv
module topo_sort_tree
  import jet_topo_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int NUM_CANDS = NUM_SRC * CANDS_PER_SRC,
  localparam int NUM_NODES = 2 * NUM_SRC - 1
) (
  input  logic  clk,
  input  logic  rst,
  input  jet_t  leaves [NUM_CANDS],
  output pair_t best
);
  pair_t node [NUM_NODES];

  // heap layout: node n has children 2n+1 (lower indices) and 2n+2
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_leaf
    localparam int B = s * CANDS_PER_SRC;
    always_ff @(posedge clk) begin
      if (rst) node[NUM_SRC-1+s] <= '0;
      else node[NUM_SRC-1+s] <= mergePairs(sortTwo(leaves[B], leaves[B+1]),
                                           sortTwo(leaves[B+2], leaves[B+3]));
    end
  end

  for (genvar n = 0; n < NUM_SRC - 1; n++) begin : g_merge
    always_ff @(posedge clk) begin
      if (rst) node[n] <= '0;
      else     node[n] <= mergePairs(node[2*n+1], node[2*n+2]);
    end
  end

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_chk
    // R4: each stored pair is in rank order
    a_r4_node_order: assert property (@(posedge clk) disable iff (rst)
      {node[n].first.energy, node[n].first.valid} >=
      {node[n].second.energy, node[n].second.valid});
    // R5: a present runner-up never sits under an absent leader
    a_r5_valid_order: assert property (@(posedge clk) disable iff (rst)
      node[n].second.valid |-> node[n].first.valid);
  end

  assign best = node[0];
endmodule

// File: rtl/topo_datapath.sv
module topo_datapath
  import jet_topo_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int NUM_CANDS = NUM_SRC * CANDS_PER_SRC,
  localparam int UNUSED_W = NUM_SRC * (PRES_W - CANDS_PER_SRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobes_t                    strobes,
  input  logic [NUM_CANDS*CAND_W-1:0] srcCands,
  input  logic [NUM_SRC*PRES_W-1:0]   srcPresence,
  input  logic                        lutWrEn,
  input  logic [LUT_AW-1:0]           lutWrAddr,
  input  logic                        lutWrData,
  output logic                        decision
);
  jet_t              inReg [NUM_CANDS];
  pair_t             best;
  logic              lutMem [LUT_DEPTH];
  logic [LUT_AW-1:0] lookAddr;
  logic [NUM_CANDS-1:0] capturedValid;
  logic [UNUSED_W-1:0]  unusedPresence;

  for (genvar i = 0; i < NUM_CANDS; i++) begin : g_in
    localparam int S = i / CANDS_PER_SRC;
    localparam int K = i % CANDS_PER_SRC;
    logic [CAND_W-1:0] word;
    logic              present;
    assign word    = srcCands[i*CAND_W +: CAND_W];
    assign present = srcPresence[S*PRES_W+K] & strobes.captureFrame;
    always_ff @(posedge clk) begin
      if (rst) inReg[i] <= '0;
      else begin
        inReg[i].energy <= present ? word[CAND_W-1 -: ENERGY_W] : '0;
        inReg[i].valid  <= present;
        inReg[i].eta    <= present ? word[PHI_W +: ETA_W] : '0;
        inReg[i].phi    <= present ? word[PHI_W-1:0] : '0;
      end
    end
    assign capturedValid[i] = inReg[i].valid;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_spare
    localparam int SW = PRES_W - CANDS_PER_SRC;
    assign unusedPresence[s*SW +: SW] = srcPresence[s*PRES_W+CANDS_PER_SRC +: SW];
  end

  topo_sort_tree #(.NUM_SRC(NUM_SRC)) i_tree (
    .clk(clk), .rst(rst), .leaves(inReg), .best(best)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LUT_DEPTH; i++) lutMem[i] <= 1'b0;
    end else if (lutWrEn) begin
      lutMem[lutWrAddr] <= lutWrData;
    end
  end

  assign lookAddr = {best.first.eta, best.first.phi, best.second.eta, best.second.phi};

  always_ff @(posedge clk) begin
    if (rst) decision <= 1'b0;
    else decision <= strobes.decideFrame & best.first.valid &
                     best.second.valid & lutMem[lookAddr];
  end

  // R5: a raised decision needs a present runner-up from the tree
  a_r5_pair_required: assert property (@(posedge clk) disable iff (rst)
    decision |-> $past(best.second.valid));
  // R2: an unqualified frame is captured with no present candidate
  a_r2_gated_capture: assert property (@(posedge clk) disable iff (rst)
    !$past(strobes.captureFrame) |-> (capturedValid == '0));
  // R7: a write lands at its address
  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    $past(lutWrEn) |-> (lutMem[$past(lutWrAddr)] == $past(lutWrData)));
endmodule

// File: rtl/jet_pair_trigger.sv
module jet_pair_trigger
  import jet_topo_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int NUM_CANDS = NUM_SRC * CANDS_PER_SRC,
  localparam int TREE_DEPTH = 1 + $clog2(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frameValid,
  input  logic [NUM_CANDS*CAND_W-1:0] srcCands,
  input  logic [NUM_SRC*PRES_W-1:0]   srcPresence,
  input  logic                        lutWrEn,
  input  logic [LUT_AW-1:0]           lutWrAddr,
  input  logic                        lutWrData,
  output logic                        decision
);
  strobes_t strobes;

  topo_ctrl #(.TREE_DEPTH(TREE_DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .frameValid(frameValid), .strobes(strobes)
  );

  topo_datapath #(.NUM_SRC(NUM_SRC)) i_datapath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .srcCands(srcCands), .srcPresence(srcPresence),
    .lutWrEn(lutWrEn), .lutWrAddr(lutWrAddr), .lutWrData(lutWrData),
    .decision(decision)
  );
endmodule

// File: tb/test_jet_pair_trigger.sv
module test_jet_pair_trigger;
  localparam int NSRC = 32;
  localparam int NC = NSRC * 4;
  localparam int CW = 14;
  localparam int LAT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameValid = 1'b0;
  logic lutWrEn = 1'b0;
  logic lutWrData = 1'b0;
  logic [11:0] lutWrAddr = '0;
  logic [NC*CW-1:0] srcCands = '0;
  logic [NSRC*8-1:0] srcPresence = '0;
  logic decision;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit refLut [4096];
  bit qV [$];
  int qA [$];
  string qT [$];

  always #10 clk = ~clk;

  jet_pair_trigger i_jet_pair_trigger (
    .clk(clk), .rst(rst), .frameValid(frameValid),
    .srcCands(srcCands), .srcPresence(srcPresence),
    .lutWrEn(lutWrEn), .lutWrAddr(lutWrAddr), .lutWrData(lutWrData),
    .decision(decision)
  );

  function automatic int candKey(int i);
    int e;
    e = int'(srcCands[i*CW+6 +: 8]);
    if (frameValid && srcPresence[(i/4)*8 + (i%4)]) return e * 2 + 1;
    return 0;
  endfunction

  task automatic pushFrame(string tag);
    int b1, b2, a;
    b1 = 0;
    for (int i = 1; i < NC; i++) if (candKey(i) > candKey(b1)) b1 = i;
    b2 = (b1 == 0) ? 1 : 0;
    for (int i = 0; i < NC; i++)
      if (i != b1 && candKey(i) > candKey(b2)) b2 = i;
    a = (int'(srcCands[b1*CW +: 6]) << 6) | int'(srcCands[b2*CW +: 6]);
    qV.push_back(((candKey(b1) % 2) == 1) && ((candKey(b2) % 2) == 1));
    qA.push_back(a);
    qT.push_back(tag);
  endtask

  task automatic tick(string tag);
    bit ev, expD;
    int ea;
    string et;
    pushFrame(tag);
    @(posedge clk);
    ev = qV.pop_front();
    ea = qA.pop_front();
    et = qT.pop_front();
    expD = ev && refLut[ea];
    if (lutWrEn) refLut[lutWrAddr] = lutWrData;
    @(negedge clk);
    compared++;
    if (decision !== expD) begin
      mismatched++;
      $display("FAIL %s: decision=%0b expected=%0b", et, decision, expD);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    lutWrEn = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4096; i++) refLut[i] = 1'b0;
    qV.delete(); qA.delete(); qT.delete();
    for (int i = 0; i < LAT; i++) begin
      qV.push_back(1'b0); qA.push_back(0); qT.push_back("R1");
    end
  endtask

  task automatic setCand(int s, int k, int e, int eta, int phi, bit p);
    srcCands[(s*4+k)*CW +: CW] = {e[7:0], eta[2:0], phi[2:0]};
    srcPresence[s*8+k] = p;
  endtask

  task automatic clearFrame();
    srcCands = '0;
    srcPresence = '0;
  endtask

  task automatic randFrame(int eMax, int pct);
    for (int s = 0; s < NSRC; s++) begin
      for (int k = 0; k < 4; k++)
        setCand(s, k, $urandom_range(eMax, 0), $urandom_range(7, 0),
                $urandom_range(7, 0), $urandom_range(99, 0) < pct);
      srcPresence[s*8+4 +: 4] = 4'($urandom);
    end
  endtask

  function automatic bit ruleBit(int a);
    int e1, p1, e2, p2, d, sep;
    e1 = (a >> 9) & 7; p1 = (a >> 6) & 7; e2 = (a >> 3) & 7; p2 = a & 7;
    d = (p1 - p2 + 8) % 8;
    sep = (d > 4) ? 8 - d : d;
    return (sep >= 3) || (sep == 2 && e1 > e2);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run incomplete, done=%0b expected=1", done);
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state and empty table give 0 for full frames
    frameValid = 1'b1;
    for (int n = 0; n < 40; n++) begin randFrame(255, 80); tick("R1"); end

    // R7: load the table while frames are unqualified
    frameValid = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      lutWrEn = 1'b1; lutWrAddr = 12'(a); lutWrData = ruleBit(a);
      randFrame(255, 50);
      tick("R7");
    end
    lutWrEn = 1'b0;

    // R6 directed: leader/runner-up order selects the address
    frameValid = 1'b1;
    clearFrame();
    setCand(5, 2, 200, 1, 0, 1'b1);
    setCand(20, 0, 100, 0, 2, 1'b1);
    tick("R6");
    clearFrame();
    setCand(5, 2, 100, 1, 0, 1'b1);
    setCand(20, 0, 200, 0, 2, 1'b1);
    tick("R6");

    // R6 and R8: random back-to-back frames
    for (int n = 0; n < 1500; n++) begin randFrame(255, 60); tick("R6"); end
    for (int n = 0; n < 300; n++) begin
      frameValid = n[0] | n[2];
      randFrame(255, 40);
      tick("R8");
    end
    frameValid = 1'b1;

    // R4: heavy energy ties
    for (int n = 0; n < 400; n++) begin randFrame(2, 50); tick("R4"); end
    clearFrame();
    setCand(3, 1, 0, 0, 0, 1'b1);
    setCand(9, 3, 0, 2, 5, 1'b1);
    tick("R4");

    // R5: fewer than two present candidates
    for (int n = 0; n < 300; n++) begin randFrame(255, 1); tick("R5"); end
    clearFrame();
    setCand(7, 0, 255, 0, 4, 1'b1);
    for (int s = 0; s < NSRC; s++) setCand(s, 3, 250, 3, 0, 1'b0);
    tick("R5");

    // R3: upper presence bits alone present nothing
    clearFrame();
    for (int s = 0; s < NSRC; s++) begin
      for (int k = 0; k < 4; k++) setCand(s, k, 255, 0, 4, 1'b0);
      srcPresence[s*8+4 +: 4] = 4'hF;
    end
    tick("R3");
    for (int n = 0; n < 200; n++) begin randFrame(255, 30); tick("R3"); end

    // R2: unqualified frames
    frameValid = 1'b0;
    for (int n = 0; n < 200; n++) begin randFrame(255, 90); tick("R2"); end
    frameValid = 1'b1;

    // R7: table writes during live traffic
    for (int n = 0; n < 600; n++) begin
      lutWrEn = $urandom_range(1, 0) == 1;
      lutWrAddr = 12'($urandom);
      lutWrData = $urandom_range(3, 0) != 0;
      randFrame(255, 60);
      tick("R7");
    end
    lutWrEn = 1'b0;

    // R1: a second reset clears the table again
    doReset();
    for (int n = 0; n < 60; n++) begin randFrame(255, 80); tick("R1"); end

    done = 1;
    summary();
    $finish;
  end
endmodule